// File: doc/BRIEF.md
# PTP Offset and Mean Path Delay Calculator

This block follows one two-way time-transfer exchange between a master clock and a slave clock. It collects the four timestamps of that exchange and produces the mean path delay and the slave's signed offset from the master. The calculation assumes that the delay from master to slave equals the delay from slave to master.

An upstream parser and a timestamp capture unit present one event per cycle. Each event carries a 2-bit kind and a 64-bit nanosecond stamp. The four kinds are Sync received, Follow_Up content, Delay_Req sent and Delay_Resp content. With two-step operation the master's send time of Sync (T1) arrives later in a Follow_Up. With one-step operation T1 comes on a separate origin input together with the Sync, and no Follow_Up is expected.

The block checks that the messages arrive in a legal order. It raises a one-cycle error pulse for a message that arrives out of order and for an exchange whose computed delay is negative. A Sync is always accepted and restarts the exchange from that Sync.

Top module: `ptp_exchange_calc`

## Requirements
- R1: After reset, `res_valid`, `seq_err`, `res_delay` and `res_offset` are zero and the exchange is idle, so the first event that is not a Sync is flagged as an error.
- R2: The event kind encodings are 0 = Sync received (stamp is T2), 1 = Follow_Up (stamp is T1), 2 = Delay_Req sent (stamp is T3) and 3 = Delay_Resp (stamp is T4).
- R3: In two-step operation, the order Sync, Follow_Up, Delay_Req, Delay_Resp produces a result.
- R4: When `one_step` is high with a Sync, T1 is taken from `ev_origin`, and the next expected event is Delay_Req. A Follow_Up in that exchange is an error.
- R5: `res_delay` equals ((T2 − T1) + (T4 − T3)) shifted right arithmetically by one bit.
- R6: `res_offset` equals ((T2 − T1) − (T4 − T3)) shifted right arithmetically by one bit, as a signed value. A positive value means the slave is ahead of the master.
- R7: `res_valid` is high for exactly one cycle, in the cycle after the edge that accepts the Delay_Resp. `res_delay` and `res_offset` change only with `res_valid`.
- R8: An event that does not fit the current stage raises `seq_err` for one cycle, in the cycle after it is sampled, and returns the exchange to idle.
- R9: A Sync in any stage restarts the exchange from that Sync without raising `seq_err`.
- R10: If the sum (T2 − T1) + (T4 − T3) is negative, the Delay_Resp raises `seq_err` and `res_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 2 | Event kind (0 Sync, 1 Follow_Up, 2 Delay_Req, 3 Delay_Resp) |
| ev_stamp | input | 64 | Timestamp carried by the event, in nanoseconds |
| ev_origin | input | 64 | T1 delivered with a one-step Sync |
| one_step | input | 1 | The Sync on this cycle is a one-step Sync |
| res_valid | output | 1 | One-cycle result strobe |
| res_offset | output | 64 | Signed offset of the slave from the master |
| res_delay | output | 64 | Mean path delay |
| seq_err | output | 1 | One-cycle pulse for an illegal order or a negative delay |

## Verification
Every outcome of this block falls due one cycle after the clock edge that samples the event that causes it. That edge registers `res_valid`, `seq_err`, `res_delay` and `res_offset` together, and no other register sits between the event and these outputs. The bench drives each event on a falling edge and updates its reference model on the rising edge that samples the event. It compares the outputs on the next falling edge, which is inside the cycle where they must show. Directed checks read the outputs at the falling edge just after the event's task returns. A check taken one falling edge later confirms that the strobe has cleared again.

// File: rtl/ptp_exchange_calc.sv
module ptp_exchange_calc #(
  parameter int TS_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_valid,
  input  logic [1:0]             ev_kind,
  input  logic [TS_W-1:0]        ev_stamp,
  input  logic [TS_W-1:0]        ev_origin,
  input  logic                   one_step,
  output logic                   res_valid,
  output logic signed [TS_W-1:0] res_offset,
  output logic [TS_W-1:0]        res_delay,
  output logic                   seq_err
);

  localparam logic [1:0] K_SYNC = 2'd0;
  localparam logic [1:0] K_FUP  = 2'd1;
  localparam logic [1:0] K_DREQ = 2'd2;
  localparam logic [1:0] K_DRSP = 2'd3;
  localparam int DW = TS_W + 1;
  localparam int SW = TS_W + 2;

  typedef enum logic [2:0] {
    S_IDLE, S_GOT_SYNC, S_GOT_T1, S_SENT_REQ, S_DONE
  } stage_t;

  stage_t          st_q;
  logic [TS_W-1:0] t1_q, t2_q, t3_q;

  logic signed [DW-1:0] fwd, rev;
  logic signed [SW-1:0] sum, dif, half_sum, half_dif;
  logic                 unused_bits;

  assign fwd      = $signed({1'b0, t2_q}) - $signed({1'b0, t1_q});
  assign rev      = $signed({1'b0, ev_stamp}) - $signed({1'b0, t3_q});
  assign sum      = SW'(fwd) + SW'(rev);
  assign dif      = SW'(fwd) - SW'(rev);
  assign half_sum = sum >>> 1;
  assign half_dif = dif >>> 1;
  assign unused_bits = ^{half_sum[SW-1:TS_W], half_dif[SW-1:TS_W]};

  logic fup_ok, dreq_ok, drsp_ok;
  assign fup_ok  = (st_q == S_GOT_SYNC);
  assign dreq_ok = (st_q == S_GOT_T1);
  assign drsp_ok = (st_q == S_SENT_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      t1_q       <= '0;
      t2_q       <= '0;
      t3_q       <= '0;
      res_valid  <= 1'b0;
      seq_err    <= 1'b0;
      res_delay  <= '0;
      res_offset <= '0;
    end else begin
      res_valid <= 1'b0;
      seq_err   <= 1'b0;
      if (st_q == S_DONE) st_q <= S_IDLE;
      if (ev_valid) begin
        case (ev_kind)
          K_SYNC: begin
            t2_q <= ev_stamp;
            if (one_step) begin
              t1_q <= ev_origin;
              st_q <= S_GOT_T1;
            end else begin
              st_q <= S_GOT_SYNC;
            end
          end
          K_FUP: begin
            if (fup_ok) begin
              t1_q <= ev_stamp;
              st_q <= S_GOT_T1;
            end else begin
              seq_err <= 1'b1;
              st_q    <= S_IDLE;
            end
          end
          K_DREQ: begin
            if (dreq_ok) begin
              t3_q <= ev_stamp;
              st_q <= S_SENT_REQ;
            end else begin
              seq_err <= 1'b1;
              st_q    <= S_IDLE;
            end
          end
          default: begin
            if (drsp_ok) begin
              if (sum[SW-1]) begin
                seq_err <= 1'b1;
              end else begin
                res_valid  <= 1'b1;
                res_delay  <= half_sum[TS_W-1:0];
                res_offset <= half_dif[TS_W-1:0];
              end
              st_q <= S_DONE;
            end else begin
              seq_err <= 1'b1;
              st_q    <= S_IDLE;
            end
          end
        endcase
      end
    end
  end

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_strobe_after_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(ev_valid) && $past(ev_kind) == K_DRSP && $past(st_q) == S_SENT_REQ));

  p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_delay) && $stable(res_offset)));

  p_err_returns_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (st_q == S_IDLE || st_q == S_DONE));

  p_err_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(ev_valid));

  p_sync_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == K_SYNC) |=> !seq_err && !res_valid);

  p_neg_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && seq_err));

  p_one_step_skips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == K_SYNC && one_step) |=> (st_q == S_GOT_T1));

endmodule

// File: tb/ptp_exchange_calc_bench.sv
module ptp_exchange_calc_bench;
  localparam int W = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ev_valid, one_step;
  logic [1:0] ev_kind;
  logic [W-1:0] ev_stamp, ev_origin;
  logic res_valid, seq_err;
  logic signed [W-1:0] res_offset;
  logic [W-1:0] res_delay;

  ptp_exchange_calc #(.TS_W(W)) u_ptp_exchange_calc (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_stamp(ev_stamp), .ev_origin(ev_origin), .one_step(one_step),
    .res_valid(res_valid), .res_offset(res_offset), .res_delay(res_delay),
    .seq_err(seq_err));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: stage 0 idle,1 sync,2 have T1,3 req sent,4 done
  int m_st;
  longint m_t1, m_t2, m_t3, m_a, m_b, m_s;
  bit e_valid, e_err;
  longint e_delay, e_off;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; e_valid = 0; e_err = 0; e_delay = 0; e_off = 0;
    end else begin
      e_valid = 0; e_err = 0;
      if (m_st == 4) m_st = 0;
      if (ev_valid) begin
        case (ev_kind)
          2'd0: begin
            m_t2 = longint'(ev_stamp);
            if (one_step) begin m_t1 = longint'(ev_origin); m_st = 2; end
            else m_st = 1;
          end
          2'd1: if (m_st == 1) begin m_t1 = longint'(ev_stamp); m_st = 2; end
                else begin e_err = 1; m_st = 0; end
          2'd2: if (m_st == 2) begin m_t3 = longint'(ev_stamp); m_st = 3; end
                else begin e_err = 1; m_st = 0; end
          default: if (m_st == 3) begin
            m_a = m_t2 - m_t1;
            m_b = longint'(ev_stamp) - m_t3;
            m_s = m_a + m_b;
            if (m_s < 0) e_err = 1;
            else begin
              e_valid = 1;
              e_delay = m_s >>> 1;
              e_off   = (m_a - m_b) >>> 1;
            end
            m_st = 4;
          end else begin e_err = 1; m_st = 0; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(res_valid == e_valid, "R7 res_valid vs model", longint'(res_valid), longint'(e_valid));
      chk(seq_err == e_err, "R8 seq_err vs model", longint'(seq_err), longint'(e_err));
      chk(res_delay == W'(e_delay), "R5 res_delay vs model", longint'(res_delay), e_delay);
      chk(res_offset == e_off, "R6 res_offset vs model", longint'(res_offset), e_off);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic ev(input logic [1:0] k, input longint s, input longint o = 0, input bit os = 0);
    ev_valid = 1; ev_kind = k; ev_stamp = W'(s); ev_origin = W'(o); one_step = os;
    @(negedge clk);
    ev_valid = 0; one_step = 0;
  endtask

  initial begin
    rst_n = 0; ev_valid = 0; ev_kind = 0; ev_stamp = 0; ev_origin = 0; one_step = 0;
    repeat (3) @(negedge clk);
    chk(!res_valid && !seq_err && res_delay == 0 && res_offset == 0, "R1 outputs in reset",
        longint'(res_valid) + longint'(seq_err), 0);
    rst_n = 1;
    @(negedge clk);
    ev(2'd3, 50);
    chk(seq_err == 1, "R1 idle after reset flags early Delay_Resp", longint'(seq_err), 1);
    @(negedge clk);

    // two-step exchange
    ev(2'd0, 1600); ev(2'd1, 1000); ev(2'd2, 2000); ev(2'd3, 2300);
    chk(res_valid == 1, "R3 two-step result strobe", longint'(res_valid), 1);
    chk(res_delay == 450, "R2 stamps routed by kind, delay", longint'(res_delay), 450);
    chk(res_offset == 150, "R6 positive offset slave ahead", longint'(res_offset), 150);
    @(negedge clk);
    chk(res_valid == 0, "R7 strobe lasts one cycle", longint'(res_valid), 0);

    // one-step exchange
    ev(2'd0, 5000, 4900, 1); ev(2'd2, 5100); ev(2'd3, 5250);
    chk(res_delay == 125 && res_valid, "R4 one-step delay", longint'(res_delay), 125);
    chk(res_offset == -25, "R6 negative offset", longint'(res_offset), -25);
    ev(2'd0, 5001, 4900, 1); ev(2'd2, 5100); ev(2'd3, 5250);
    chk(res_delay == 125, "R5 odd sum shifts down", longint'(res_delay), 125);
    chk(res_offset == -25, "R6 odd negative difference floors", longint'(res_offset), -25);

    // out of order
    @(negedge clk);
    ev(2'd1, 7);
    chk(seq_err == 1, "R8 Follow_Up while idle", longint'(seq_err), 1);
    ev(2'd2, 9);
    chk(seq_err == 1, "R8 stays idle after error", longint'(seq_err), 1);
    ev(2'd0, 100); ev(2'd2, 150);
    chk(seq_err == 1, "R8 Delay_Req before Follow_Up", longint'(seq_err), 1);

    // restart
    ev(2'd0, 1600); ev(2'd1, 1000); ev(2'd0, 8000);
    chk(seq_err == 0, "R9 second Sync not an error", longint'(seq_err), 0);
    ev(2'd1, 7700); ev(2'd2, 9000); ev(2'd3, 9100);
    chk(res_valid && res_delay == 200, "R9 result from restarted exchange", longint'(res_delay), 200);
    chk(res_offset == 100, "R9 offset from restarted exchange", longint'(res_offset), 100);

    // negative delay
    ev(2'd0, 1010, 1000, 1); ev(2'd2, 2000); ev(2'd3, 1900);
    chk(seq_err == 1, "R10 negative delay flagged", longint'(seq_err), 1);
    chk(res_valid == 0, "R10 no result strobe", longint'(res_valid), 0);

    // follow-up in one-step exchange
    ev(2'd0, 3000, 2900, 1); ev(2'd1, 2900);
    chk(seq_err == 1, "R4 Follow_Up after one-step Sync", longint'(seq_err), 1);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      longint t1, t2, t3, t4;
      bit os;
      os = $urandom % 2;
      t1 = longint'($urandom % 100000);
      t2 = t1 + longint'($urandom % 500);
      t3 = t2 + longint'($urandom % 500);
      t4 = t3 + longint'($urandom % 600) - 60;
      ev(2'd0, t2, t1, os);
      if ($urandom % 10 == 0) ev(2'($urandom % 4), longint'($urandom % 1000));
      if (!os) ev(2'd1, t1);
      repeat ($urandom % 3) @(negedge clk);
      ev(2'd2, t3);
      if ($urandom % 10 == 0) ev(2'($urandom % 4), longint'($urandom % 1000));
      ev(2'd3, t4);
      repeat ($urandom % 3) @(negedge clk);
    end

    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule